// File: doc/BRIEF.md
# Up/Down Counter with Clear/Gate Input

This block is a single up/down counter channel whose count source is chosen by a mode field. In timer mode it advances once per clock. In two-input mode it counts up on rising edges of one tracking input and down on rising edges of the other. In phase mode it counts on rising edges of the first tracking input, and the level of the second input at that moment sets the direction. This decodes a two-phase sensor once per cycle of its first input.

A third external input, the control pin, serves one of two roles. In the clear role it zeroes the counter on a chosen edge. In the gate role it allows counting only while the pin sits at a chosen level. A two-bit select picks the polarity in both roles. The select value 11 is not a valid setting. It is treated as "off" and it sets a sticky status bit. All three external inputs pass through a two-flop synchronizer before any edge or level is decoded.

A six-bit configuration word, written through a write strobe, holds the start bit, the role bit, the select field and the mode. The count value, the direction of the last step and one-cycle wrap flags are outputs.

Top module: `updn_ctr`

## Requirements
- R1: A write with `cfg_we_i` high loads `cfg_wdata_i` on that clock edge and takes effect from the next cycle. The fields are: bit 0 is start, bit 1 is role (0 = clear, 1 = gate), bits 3:2 are select, and bits 5:4 are mode (00 timer, 01 two-input, 10 phase, 11 no counting). After reset the configuration, count, direction and all flags are zero.
- R2: Each external input goes through two synchronizer flops plus one history flop. A change on a tracking input that causes a count step appears on `count_o` after the third rising clock edge following the change.
- R3: While start is 0 the count does not step in any mode.
- R4: In timer mode with counting allowed, the count rises by exactly one per clock.
- R5: In two-input mode, a rising edge of `trk_a_i` adds one and a rising edge of `trk_b_i` subtracts one. Rising edges of both inputs in the same cycle leave the count unchanged, and falling edges do nothing.
- R6: In phase mode, a rising edge of `trk_a_i` adds one when `trk_b_i` is low and subtracts one when it is high. Falling edges of `trk_a_i` and any edge of `trk_b_i` do nothing.
- R7: In the clear role, select 01 zeroes the count on a falling edge of `ctl_i` and select 10 zeroes it on a rising edge. Selects 00 and 11 never clear. The clear works whatever the start bit and mode are.
- R8: When a clear and a count step fall in the same cycle, the clear wins and the count becomes zero.
- R9: In the gate role, select 01 allows counting only while `ctl_i` is low and select 10 only while it is high. Selects 00 and 11 block counting.
- R10: The counter wraps from all-ones to zero, raising `ovf_o` for that one cycle, and from zero to all-ones, raising `udf_o` for that one cycle. The two flags are never high together.
- R11: `dir_o` is 0 after an up step and 1 after a down step. It keeps its value through a clear and through idle cycles.
- R12: While the active select field is 11, `bad_sel_o` goes high one cycle later and then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 6 | Configuration word: start, role, select, mode |
| trk_a_i | input | 1 | First tracking input (asynchronous) |
| trk_b_i | input | 1 | Second tracking input (asynchronous) |
| ctl_i | input | 1 | Clear/gate control input (asynchronous) |
| count_o | output | W | Counter value |
| dir_o | output | 1 | Direction of the last step (1 = down) |
| ovf_o | output | 1 | One-cycle wrap-up flag |
| udf_o | output | 1 | One-cycle wrap-down flag |
| bad_sel_o | output | 1 | Sticky flag for select code 11 |

## Verification
Directed sequences drive single edges on each input in each mode. These show which edge polarity and which input level step the count, and in which cycle the step appears. Clear and gate are tried with every select code, including 11, so that a polarity swap or a missing "off" decode shows up as a wrong count. Running in timer mode past the top and bottom of the range separates the wrap flags from ordinary steps. A long stretch of random pin activity with random configuration writes produces clears that coincide with count events, and it is checked cycle by cycle against a model in the bench.

// File: rtl/updn_ctr_pkg.sv
package updn_ctr_pkg;

    typedef enum logic [1:0] {
        MODE_TIMER = 2'b00,
        MODE_PAIR  = 2'b01,
        MODE_PHASE = 2'b10,
        MODE_IDLE  = 2'b11
    } mode_e;

    // packed from MSB: mode[5:4], sel[3:2], gate_role[1], start[0]
    typedef struct packed {
        mode_e      mode;
        logic [1:0] sel;
        logic       gate_role;
        logic       start;
    } cfg_t;

    localparam int CFG_W   = $bits(cfg_t);
    localparam int NPINS   = 3;
    localparam int IDX_A   = 0;
    localparam int IDX_B   = 1;
    localparam int IDX_C   = 2;

    localparam logic [1:0] SEL_OFF  = 2'b00;
    localparam logic [1:0] SEL_LOW  = 2'b01;
    localparam logic [1:0] SEL_HIGH = 2'b10;
    localparam logic [1:0] SEL_BAD  = 2'b11;

endpackage

// File: rtl/updn_ctr_sync.sv
module updn_ctr_sync #(
    parameter int N = 3
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);

    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
        logic [N-1:0] hist;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = pin_i;
        st_d.s2   = st_q.s1;
        st_d.hist = st_q.s2;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_edge
        assign lvl_o[i]  = st_q.s2[i];
        assign rise_o[i] = st_q.s2[i] & ~st_q.hist[i];
        assign fall_o[i] = ~st_q.s2[i] & st_q.hist[i];
    end

endmodule

// File: rtl/updn_ctr_evt.sv
module updn_ctr_evt
    import updn_ctr_pkg::*;
(
    input  cfg_t             cfg_i,
    input  logic [NPINS-1:0] lvl_i,
    input  logic [NPINS-1:0] rise_i,
    input  logic [NPINS-1:0] fall_i,
    output logic             inc_o,
    output logic             dec_o,
    output logic             clr_o
);

    logic gate_ok;
    logic run;

    always_comb begin
        // gate role: only the two legal level codes ever open the gate
        if (cfg_i.gate_role) begin
            unique case (cfg_i.sel)
                SEL_LOW:  gate_ok = ~lvl_i[IDX_C];
                SEL_HIGH: gate_ok = lvl_i[IDX_C];
                default:  gate_ok = 1'b0;
            endcase
        end else begin
            gate_ok = 1'b1;
        end

        // clear role: edge select, codes 00 and 11 never clear
        clr_o = 1'b0;
        if (!cfg_i.gate_role) begin
            unique case (cfg_i.sel)
                SEL_LOW:  clr_o = fall_i[IDX_C];
                SEL_HIGH: clr_o = rise_i[IDX_C];
                default:  clr_o = 1'b0;
            endcase
        end

        run   = cfg_i.start & gate_ok;
        inc_o = 1'b0;
        dec_o = 1'b0;
        unique case (cfg_i.mode)
            MODE_TIMER: begin
                inc_o = run;
            end
            MODE_PAIR: begin
                inc_o = run & rise_i[IDX_A] & ~rise_i[IDX_B];
                dec_o = run & rise_i[IDX_B] & ~rise_i[IDX_A];
            end
            MODE_PHASE: begin
                inc_o = run & rise_i[IDX_A] & ~lvl_i[IDX_B];
                dec_o = run & rise_i[IDX_A] & lvl_i[IDX_B];
            end
            default: begin
                inc_o = 1'b0;
                dec_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/updn_ctr.sv
module updn_ctr
    import updn_ctr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         cfg_we_i,
    input  logic [5:0]   cfg_wdata_i,
    input  logic         trk_a_i,
    input  logic         trk_b_i,
    input  logic         ctl_i,
    output logic [W-1:0] count_o,
    output logic         dir_o,
    output logic         ovf_o,
    output logic         udf_o,
    output logic         bad_sel_o
);

    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};
    localparam logic [W-1:0] CNT_ONE = W'(1);

    typedef struct packed {
        logic [W-1:0] count;
        logic         dir;
        logic         ovf;
        logic         udf;
        logic         bad;
        cfg_t         cfg;
    } state_t;

    state_t st_d, st_q;

    logic [NPINS-1:0] pins;
    logic [NPINS-1:0] lvl;
    logic [NPINS-1:0] rise;
    logic [NPINS-1:0] fall;
    logic             inc_w;
    logic             dec_w;
    logic             clr_w;

    assign pins[IDX_A] = trk_a_i;
    assign pins[IDX_B] = trk_b_i;
    assign pins[IDX_C] = ctl_i;

    updn_ctr_sync #(
        .N(NPINS)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_i  (pins),
        .lvl_o  (lvl),
        .rise_o (rise),
        .fall_o (fall)
    );

    updn_ctr_evt u_evt (
        .cfg_i  (st_q.cfg),
        .lvl_i  (lvl),
        .rise_i (rise),
        .fall_i (fall),
        .inc_o  (inc_w),
        .dec_o  (dec_w),
        .clr_o  (clr_w)
    );

    always_comb begin
        st_d     = st_q;
        st_d.ovf = 1'b0;
        st_d.udf = 1'b0;

        if (cfg_we_i) begin
            st_d.cfg = cfg_t'(cfg_wdata_i[CFG_W-1:0]);
        end

        if (st_q.cfg.sel == SEL_BAD) begin
            st_d.bad = 1'b1;
        end

        if (clr_w) begin
            st_d.count = '0;
        end else if (inc_w) begin
            st_d.count = st_q.count + CNT_ONE;
            st_d.dir   = 1'b0;
            st_d.ovf   = (st_q.count == CNT_MAX);
        end else if (dec_w) begin
            st_d.count = st_q.count - CNT_ONE;
            st_d.dir   = 1'b1;
            st_d.udf   = (st_q.count == '0);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o   = st_q.count;
    assign dir_o     = st_q.dir;
    assign ovf_o     = st_q.ovf;
    assign udf_o     = st_q.udf;
    assign bad_sel_o = st_q.bad;

endmodule

// File: rtl/updn_ctr_chk.sv
module updn_ctr_chk #(
    parameter int W = 16
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic [W-1:0] count_i,
    input logic         dir_i,
    input logic         ovf_i,
    input logic         udf_i,
    input logic         bad_i,
    input logic         start_i,
    input logic         inc_i,
    input logic         dec_i,
    input logic         clr_i
);

    p_flags_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones({ovf_i, udf_i}) <= 1);

    p_ovf_wrap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_i |-> (count_i == '0) && !dir_i);

    p_udf_wrap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        udf_i |-> (count_i == {W{1'b1}}) && dir_i);

    p_clear_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (count_i == '0) && !ovf_i && !udf_i);

    p_no_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!start_i && !clr_i) |=> (count_i == $past(count_i)));

    p_step_up_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inc_i && !clr_i) |=> (count_i == W'($past(count_i) + 1'b1)) && !dir_i);

    p_step_dn_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dec_i && !clr_i) |=> (count_i == W'($past(count_i) - 1'b1)) && dir_i);

    p_bad_sticky_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bad_i |=> bad_i);

    p_idle_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!inc_i && !dec_i) |=> $stable(dir_i));

endmodule

bind updn_ctr updn_ctr_chk #(.W(W)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .count_i (count_o),
    .dir_i   (dir_o),
    .ovf_i   (ovf_o),
    .udf_i   (udf_o),
    .bad_i   (bad_sel_o),
    .start_i (st_q.cfg.start),
    .inc_i   (inc_w),
    .dec_i   (dec_w),
    .clr_i   (clr_w)
);

// File: tb/updn_ctr_bench.sv
module updn_ctr_bench;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         we = 1'b0;
    logic [5:0]   wd = '0;
    logic         pa = 1'b0;
    logic         pb = 1'b0;
    logic         pc = 1'b0;
    logic [W-1:0] count;
    logic         dir, ovf, udf, bad;

    int nchk  = 0;
    int nfail = 0;
    string tag = "R1";

    always #10 clk = ~clk;

    updn_ctr #(.W(W)) u_updn_ctr (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .cfg_we_i    (we),
        .cfg_wdata_i (wd),
        .trk_a_i     (pa),
        .trk_b_i     (pb),
        .ctl_i       (pc),
        .count_o     (count),
        .dir_o       (dir),
        .ovf_o       (ovf),
        .udf_o       (udf),
        .bad_sel_o   (bad)
    );

    // ---------------- reference model built from the requirements -------------
    logic [5:0]   m_cfg;
    logic [2:0]   m_s1, m_s2, m_h;
    logic [W-1:0] m_cnt;
    logic         m_dir, m_ovf, m_udf, m_bad;
    logic         e_inc, e_dec, e_clr, e_run, e_gok;
    logic [2:0]   e_r, e_f;

    function automatic logic [5:0] cw(input logic st, input logic gt,
                                      input logic [1:0] sel, input logic [1:0] md);
        return {md, sel, gt, st};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cfg <= '0; m_s1 <= '0; m_s2 <= '0; m_h <= '0;
            m_cnt <= '0; m_dir <= 1'b0; m_ovf <= 1'b0; m_udf <= 1'b0; m_bad <= 1'b0;
        end else begin
            e_r = m_s2 & ~m_h;
            e_f = ~m_s2 & m_h;
            e_gok = !m_cfg[1] || (m_cfg[3:2] == 2'b01 && !m_s2[2])
                              || (m_cfg[3:2] == 2'b10 && m_s2[2]);
            e_clr = !m_cfg[1] && ((m_cfg[3:2] == 2'b01 && e_f[2])
                              || (m_cfg[3:2] == 2'b10 && e_r[2]));
            e_run = m_cfg[0] && e_gok;
            e_inc = 1'b0; e_dec = 1'b0;
            case (m_cfg[5:4])
                2'b00: e_inc = e_run;
                2'b01: begin e_inc = e_run && e_r[0] && !e_r[1];
                             e_dec = e_run && e_r[1] && !e_r[0]; end
                2'b10: begin e_inc = e_run && e_r[0] && !m_s2[1];
                             e_dec = e_run && e_r[0] && m_s2[1]; end
                default: ;
            endcase
            m_s1 <= {pc, pb, pa}; m_s2 <= m_s1; m_h <= m_s2;
            if (we) m_cfg <= wd;
            if (m_cfg[3:2] == 2'b11) m_bad <= 1'b1;
            m_ovf <= 1'b0; m_udf <= 1'b0;
            if (e_clr) m_cnt <= '0;
            else if (e_inc) begin
                m_cnt <= m_cnt + 1'b1; m_dir <= 1'b0; m_ovf <= (m_cnt == '1);
            end else if (e_dec) begin
                m_cnt <= m_cnt - 1'b1; m_dir <= 1'b1; m_udf <= (m_cnt == '0);
            end
        end
    end

    // ---------------- checking helpers ----------------
    task automatic check(input logic ok, input string t, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", t, act, exp);
        end
    endtask

    task automatic cmp_model();
        check(count == m_cnt, {tag, " count"}, count, m_cnt);
        check({dir, ovf, udf, bad} == {m_dir, m_ovf, m_udf, m_bad},
              {tag, " flags dir/ovf/udf/bad"}, {dir, ovf, udf, bad}, {m_dir, m_ovf, m_udf, m_bad});
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cmp_model();
        end
    endtask

    task automatic wr(input logic [5:0] v);
        wd = v; we = 1'b1;
        step(1);
        we = 1'b0;
        step(1);
    endtask

    task automatic pulse_a();  pa = 1'b1; step(4); pa = 1'b0; step(4); endtask
    task automatic pulse_b();  pb = 1'b1; step(4); pb = 1'b0; step(4); endtask

    initial begin : watchdog
        #(200000 * 20);
        nfail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin : main
        logic [W-1:0] c0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(1);
        tag = "R1";
        check(count == 0 && !dir && !ovf && !udf && !bad, "R1 reset state", count, 0);

        // R3: start off, timer mode, clear role select off
        tag = "R3";
        wr(cw(0, 0, 2'b00, 2'b00));
        step(5);
        check(count == 0, "R3 no count while stopped", count, 0);

        // R4 timer
        tag = "R4";
        wr(cw(1, 0, 2'b00, 2'b00));
        c0 = count;
        step(1);
        check(count == W'(c0 + 1), "R4 one step per clock", count, W'(c0 + 1));

        // R10: run up to wrap
        tag = "R10";
        while (count != '1) step(1);
        step(1);
        check(count == 0 && ovf, "R10 wrap up flag", {ovf, count}, 256);
        step(1);
        check(!ovf, "R10 ovf one cycle", ovf, 0);

        // R5 pair mode, R2 latency
        tag = "R5";
        wr(cw(1, 0, 2'b00, 2'b01));
        c0 = count;
        tag = "R2";
        pa = 1'b1;
        step(2);
        check(count == c0, "R2 no step before third edge", count, c0);
        step(1);
        check(count == W'(c0 + 1), "R2 step at third edge", count, W'(c0 + 1));
        pa = 1'b0; step(4);
        tag = "R5";
        c0 = count;
        pulse_b(); pulse_b();
        check(count == W'(c0 - 2), "R5 down on second input", count, W'(c0 - 2));
        check(dir == 1'b1, "R11 dir after down", dir, 1);
        pa = 1'b1; pb = 1'b1; step(4); pa = 1'b0; pb = 1'b0; step(4);
        check(count == W'(c0 - 2), "R5 simultaneous edges cancel", count, W'(c0 - 2));

        // R6 phase mode
        tag = "R6";
        wr(cw(1, 0, 2'b00, 2'b10));
        c0 = count;
        pulse_a();
        check(count == W'(c0 + 1), "R6 up with second input low", count, W'(c0 + 1));
        pb = 1'b1; step(4);
        pulse_a();
        check(count == c0, "R6 down with second input high", count, c0);
        pb = 1'b0; step(4);
        check(count == c0, "R6 second input edges ignored", count, c0);

        // R7 clear role, R11 dir held over clear
        tag = "R7";
        wr(cw(0, 0, 2'b01, 2'b00));
        pc = 1'b1; step(4);
        check(count == c0, "R7 rising ignored with falling select", count, c0);
        pc = 1'b0; step(4);
        check(count == 0, "R7 clear on falling edge", count, 0);
        check(dir == 1'b1, "R11 dir kept through clear", dir, 1);
        wr(cw(1, 0, 2'b10, 2'b00));
        step(6);
        pc = 1'b1; step(4);
        check(count < 4, "R7 clear on rising edge", count, 3);
        wr(cw(1, 0, 2'b00, 2'b00));
        step(3);
        pc = 1'b0; step(4); pc = 1'b1; step(4);
        check(count > 10, "R7 select off never clears", count, 15);

        // R8: timer counting while a clear edge arrives
        tag = "R8";
        wr(cw(1, 0, 2'b01, 2'b00));
        pc = 1'b0; step(3);
        check(count == 0, "R8 clear beats timer step", count, 0);
        step(4);

        // R9 gate role
        tag = "R9";
        wr(cw(1, 1, 2'b01, 2'b00));
        pc = 1'b1; step(4);
        c0 = count;
        step(5);
        check(count == c0, "R9 held while high with low select", count, c0);
        pc = 1'b0; step(8);
        check(count != c0, "R9 counts while low", count, c0 + 5);
        wr(cw(1, 1, 2'b00, 2'b00));
        c0 = count;
        step(5);
        check(count == c0, "R9 select off blocks", count, c0);

        // R12 illegal select in gate role
        tag = "R12";
        check(!bad, "R12 flag clear before bad code", bad, 0);
        wr(cw(1, 1, 2'b11, 2'b00));
        c0 = count;
        step(5);
        check(bad && count == c0, "R12 flag set and gate shut", {bad, count}, {1'b1, c0});
        wr(cw(1, 0, 2'b00, 2'b00));
        step(3);
        check(bad, "R12 flag sticky", bad, 1);

        // R10 wrap down in pair mode
        tag = "R10";
        wr(cw(1, 0, 2'b10, 2'b01));
        pc = 1'b0; step(4); pc = 1'b1; step(4);
        pulse_b();
        check(count == '1 && dir, "R10 wrap down", count, 255);

        // random phase against the model (covers R8 coincidences)
        tag = "R8 random";
        for (int k = 0; k < 4000; k++) begin
            if (k % 97 == 0) begin
                wd = 6'($urandom) | 6'b000001; we = 1'b1;
            end else begin
                we = 1'b0;
            end
            pa = 1'($urandom); pb = 1'($urandom); pc = ($urandom % 4) == 0 ? ~pc : pc;
            step(1);
        end
        we = 1'b0;
        step(4);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin : seed
        process p;
        p = process::self();
        p.srandom(32'd1234);
    end

endmodule